// File: doc/BRIEF.md
# Static Memory Read Cycle Timer

This block times read cycles on an asynchronous static memory port shared by four chip selects. A host request carries a bank index and an address. Once the block takes the request, it drives the address and the selected chip select. It keeps the active-low output enable high for a programmable number of clocks, then holds it low for a programmable number of wait states. The read data is captured at the end of that window. The address and chip select stay valid for a fixed hold time afterwards. The captured word comes back with a one-clock done pulse.

Each bank has two settings, held in a small register file. One is the output-enable assertion delay. The other is the read delay, which sets how long the output enable is held low. In page mode, a follow-on request to the same bank and the same page is served without releasing the output enable, in one clock per access. Only the first access of a burst pays the full delay. The settings can be changed only while no cycle is in progress. A write that arrives during a cycle is dropped and raises a sticky error flag. While the controller is disabled or in low-power mode, no request is taken.

Top module: `static_read_timer`

## Requirements
- R1: After reset every chip select and the output enable are high (inactive), `rspDone` and `cfgErr` are 0, every read-delay field reads 31 and every assertion-delay field reads 0.
- R2: In idle, with `ctrlEnable`=1, `lowPower`=0 and `reqValid`=1, `reqReady` is 1 and the request is taken at that clock edge. From the next cycle `memAddr` shows the request address and holds it unchanged for as long as the chip select is low.
- R3: With assertion delay D and read delay E for the bank, `memOeN` stays high for D cycles after the chip select goes low, then stays low for exactly E+1 cycles.
- R4: `memData` is sampled at the clock edge that ends the last low cycle of `memOeN`. In the following cycle `rspDone` is 1 for one cycle and `rspData` carries the sampled word.
- R5: After `memOeN` rises, the chip select stays low for HOLD_CYC cycles (default 2) and then rises. Each access therefore keeps the chip select low for D+E+1+HOLD_CYC cycles, which is 1+HOLD_CYC when D=E=0.
- R6: Only the chip select bit equal to the request's bank index goes low (bit i is bank i). Each bank uses its own D and E.
- R7: While `ctrlEnable`=0 or `lowPower`=1, `reqReady` stays 0 in idle and no chip select goes low.
- R8: Configuration map, by byte offset: bank b's assertion delay is at b*0x20+0x08 and its read delay is at b*0x20+0x0C. Each is held in bits [4:0]. Bits [31:5] read 0 and ignore writes. Other offsets read 0 and ignore writes.
- R9: A configuration write while a cycle is in progress changes no setting and sets `cfgErr`. `cfgErr` stays set until a configuration write made in idle clears it.
- R10: With `pageModeEn`=1, a request to the same bank whose address matches above the low PAGE_W bits (default 2) is taken in the last low cycle of `memOeN` (`reqReady`=1 there). The new address is driven in the next cycle, `memOeN` stays low for one more cycle, and the word is sampled and returned as in R4.
- R11: A request to another page, or any request while `pageModeEn`=0, is not taken during a cycle. The current access finishes its hold phase, and the request starts from idle with its full delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlEnable | input | 1 | Controller enable; 0 blocks new cycles |
| lowPower | input | 1 | Low-power mode; 1 blocks new cycles |
| pageModeEn | input | 1 | Enables page-mode follow-on accesses |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 7 | Configuration byte offset |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data at `cfgAddr` |
| cfgErr | output | 1 | Sticky flag: write rejected during a cycle |
| reqValid | input | 1 | Read request valid |
| reqBank | input | 2 | Bank index of the request |
| reqAddr | input | 16 | Read address |
| reqReady | output | 1 | Request taken at this edge when valid |
| rspDone | output | 1 | One-cycle pulse with returned data |
| rspData | output | 16 | Returned read data |
| memAddr | output | 16 | Memory address |
| memCsN | output | 4 | Active-low chip selects, one per bank |
| memOeN | output | 1 | Active-low output enable |
| memData | input | 16 | Memory read data |

## Verification
The hardest situation to reach from the ports is the page-mode continuation. A follow-on request is taken only if it is present in the single cycle that ends the output-enable window. It must also fall in the same page and bank. To reach it, the bench holds the next request valid from the cycle after the first one is taken, so readiness can rise only at that cycle. The memory model returns the correct word only in the exact cycle the design must sample: cycle E+1 of a fresh window, or the first cycle after a page address change. Sampling one cycle early or late therefore shows up as wrong data. A sweep of both delay settings over a 5-by-5 grid, rotated across the banks, covers the cycle arithmetic, including the zero-wait case.

// File: rtl/srt_pkg.sv
`timescale 1ns/1ps
package srt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OEDLY,
    ST_RDWAIT,
    ST_PAGE,
    ST_HOLD
  } srtState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic active;    // a cycle is in progress, chip select asserted
    logic loadAddr;  // latch request address and bank
    logic capture;   // sample memory data at this edge
  } srtStrobe_t;

endpackage

// File: rtl/srt_cfg_regs.sv
`timescale 1ns/1ps
module srt_cfg_regs #(
  parameter int NUM_BANKS = 4,
  parameter int DLY_W     = 5,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CFG_AW   = BANK_W + 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [CFG_AW-1:0]                 addr,
  input  logic [DLY_W-1:0]                  wrField,
  input  logic                              busy,
  output logic [31:0]                       rdData,
  output logic                              errFlag,
  output logic [NUM_BANKS-1:0][DLY_W-1:0]   oeDly,
  output logic [NUM_BANKS-1:0][DLY_W-1:0]   rdDly
);

  localparam logic [4:0]       OFS_OE = 5'h08;
  localparam logic [4:0]       OFS_RD = 5'h0C;
  localparam logic [DLY_W-1:0] RD_RST = {DLY_W{1'b1}};
  localparam logic [DLY_W-1:0] OE_RST = '0;

  logic [BANK_W-1:0] bankSel;
  logic              hitOe;
  logic              hitRd;
  logic              applyWr;

  assign bankSel = addr[CFG_AW-1:5];
  assign hitOe   = (addr[4:0] == OFS_OE);
  assign hitRd   = (addr[4:0] == OFS_RD);
  assign applyWr = wrEn && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        oeDly[b] <= OE_RST;
        rdDly[b] <= RD_RST;
      end
    end else if (applyWr) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bankSel == BANK_W'(b)) begin
          if (hitOe) oeDly[b] <= wrField;
          if (hitRd) rdDly[b] <= wrField;
        end
      end
    end
  end

  // Sticky rejection flag, cleared by an accepted write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errFlag <= 1'b0;
    else if (wrEn && busy) errFlag <= 1'b1;
    else if (applyWr)      errFlag <= 1'b0;
  end

  always_comb begin
    rdData = '0;
    if (hitOe) rdData[DLY_W-1:0] = oeDly[bankSel];
    if (hitRd) rdData[DLY_W-1:0] = rdDly[bankSel];
  end

  // R9: a write during a cycle leaves every setting untouched and raises the flag
  p_busy_write_dropped_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> ($stable(oeDly) && $stable(rdDly) && errFlag));

endmodule

// File: rtl/srt_ctrl.sv
`timescale 1ns/1ps
module srt_ctrl
  import srt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DLY_W     = 5,
  parameter int PAGE_TAG_W = 14,
  parameter int HOLD_CYC  = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int HOLD_W   = $clog2(HOLD_CYC + 1),
  localparam int CNT_W    = (DLY_W > HOLD_W) ? DLY_W : HOLD_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             ctrlEnable,
  input  logic                             lowPower,
  input  logic                             pageModeEn,
  input  logic                             reqValid,
  input  logic [BANK_W-1:0]                reqBank,
  input  logic [PAGE_TAG_W-1:0]            reqTag,
  input  logic [BANK_W-1:0]                curBank,
  input  logic [PAGE_TAG_W-1:0]            curTag,
  input  logic [NUM_BANKS-1:0][DLY_W-1:0]  oeDly,
  input  logic [NUM_BANKS-1:0][DLY_W-1:0]  rdDly,
  output logic                             reqReady,
  output logic                             memOeN,
  output logic                             busy,
  output srtStrobe_t                       strb
);

  srtState_t        st, stNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             modeOk;
  logic             lastOe;
  logic             pageHit;
  logic             startReq;

  assign modeOk   = ctrlEnable && !lowPower;
  assign lastOe   = ((st == ST_RDWAIT) && (cnt == '0)) || (st == ST_PAGE);
  assign pageHit  = lastOe && pageModeEn && modeOk && reqValid &&
                    (reqBank == curBank) && (reqTag == curTag);
  assign startReq = (st == ST_IDLE) && modeOk && reqValid;
  assign reqReady = ((st == ST_IDLE) && modeOk) || pageHit;
  assign busy     = (st != ST_IDLE);
  assign memOeN   = !((st == ST_RDWAIT) || (st == ST_PAGE));

  always_comb begin
    stNxt         = st;
    cntNxt        = cnt;
    strb.active   = (st != ST_IDLE);
    strb.loadAddr = 1'b0;
    strb.capture  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (startReq) begin
          strb.loadAddr = 1'b1;
          if (oeDly[reqBank] != '0) begin
            stNxt  = ST_OEDLY;
            cntNxt = CNT_W'(oeDly[reqBank]) - CNT_W'(1);
          end else begin
            stNxt  = ST_RDWAIT;
            cntNxt = CNT_W'(rdDly[reqBank]);
          end
        end
      end
      ST_OEDLY: begin
        if (cnt == '0) begin
          stNxt  = ST_RDWAIT;
          cntNxt = CNT_W'(rdDly[curBank]);
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      ST_RDWAIT, ST_PAGE: begin
        if (lastOe) begin
          strb.capture = 1'b1;
          if (pageHit) begin
            strb.loadAddr = 1'b1;
            stNxt         = ST_PAGE;
          end else begin
            stNxt  = ST_HOLD;
            cntNxt = CNT_W'(HOLD_CYC - 1);
          end
        end else begin
          cntNxt = cnt - CNT_W'(1);
        end
      end
      ST_HOLD: begin
        if (cnt == '0) stNxt = ST_IDLE;
        else           cntNxt = cnt - CNT_W'(1);
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNxt;
      cnt <= cntNxt;
    end
  end

  // R3: assertion delay expiring opens the output-enable window
  p_oedly_opens_oe_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_OEDLY && cnt == '0) |=> !memOeN);

  // R5: a window that is not continued enters the hold phase with output enable high
  p_hold_after_oe_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lastOe && !pageHit) |=> (st == ST_HOLD && memOeN));

  // R7: no cycle begins while disabled or in low-power mode
  p_no_start_blocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && !modeOk) |=> (st == ST_IDLE));

  // R10: a page continuation keeps output enable low in the next cycle
  p_page_keeps_oe_r10: assert property (@(posedge clk) disable iff (!rstN)
    pageHit |=> (st == ST_PAGE && !memOeN));

endmodule

// File: rtl/srt_datapath.sv
`timescale 1ns/1ps
module srt_datapath
  import srt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  srtStrobe_t           strb,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    memData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [NUM_BANKS-1:0] memCsN,
  output logic [BANK_W-1:0]    curBank,
  output logic [DATA_W-1:0]    rspData,
  output logic                 rspDone
);

  logic [ADDR_W-1:0] addrQ;
  logic [BANK_W-1:0] bankQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      bankQ <= '0;
    end else if (strb.loadAddr) begin
      addrQ <= reqAddr;
      bankQ <= reqBank;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData <= '0;
      rspDone <= 1'b0;
    end else begin
      rspDone <= strb.capture;
      if (strb.capture) rspData <= memData;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cs
    assign memCsN[g] = !(strb.active && (bankQ == BANK_W'(g)));
  end

  assign memAddr = addrQ;
  assign curBank = bankQ;

  // R6: at most one chip select active
  p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  // R4: every capture is followed by exactly one done pulse
  p_done_after_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> rspDone);

  // R2: address held while a cycle runs without a new load
  p_addr_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.loadAddr) |=> $stable(memAddr));

endmodule

// File: rtl/static_read_timer.sv
`timescale 1ns/1ps
module static_read_timer
  import srt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int DLY_W     = 5,
  parameter int PAGE_W    = 2,
  parameter int HOLD_CYC  = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CFG_AW   = BANK_W + 5,
  localparam int TAG_W    = ADDR_W - PAGE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlEnable,
  input  logic                 lowPower,
  input  logic                 pageModeEn,
  input  logic                 cfgWrEn,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [31:0]          cfgWrData,
  output logic [31:0]          cfgRdData,
  output logic                 cfgErr,
  input  logic                 reqValid,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 reqReady,
  output logic                 rspDone,
  output logic [DATA_W-1:0]    rspData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [NUM_BANKS-1:0] memCsN,
  output logic                 memOeN,
  input  logic [DATA_W-1:0]    memData
);

  logic [NUM_BANKS-1:0][DLY_W-1:0] oeDly;
  logic [NUM_BANKS-1:0][DLY_W-1:0] rdDly;
  logic                            busy;
  logic [BANK_W-1:0]               curBank;
  srtStrobe_t                      strb;
  logic                            unusedWrHi;

  assign unusedWrHi = ^cfgWrData[31:DLY_W];

  srt_cfg_regs #(.NUM_BANKS(NUM_BANKS), .DLY_W(DLY_W)) u_cfg (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .addr(cfgAddr),
    .wrField(cfgWrData[DLY_W-1:0]), .busy(busy), .rdData(cfgRdData),
    .errFlag(cfgErr), .oeDly(oeDly), .rdDly(rdDly)
  );

  srt_ctrl #(.NUM_BANKS(NUM_BANKS), .DLY_W(DLY_W), .PAGE_TAG_W(TAG_W),
             .HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .lowPower(lowPower),
    .pageModeEn(pageModeEn), .reqValid(reqValid), .reqBank(reqBank),
    .reqTag(reqAddr[ADDR_W-1:PAGE_W]), .curBank(curBank),
    .curTag(memAddr[ADDR_W-1:PAGE_W]), .oeDly(oeDly), .rdDly(rdDly),
    .reqReady(reqReady), .memOeN(memOeN), .busy(busy), .strb(strb)
  );

  srt_datapath #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqBank(reqBank), .reqAddr(reqAddr),
    .memData(memData), .memAddr(memAddr), .memCsN(memCsN), .curBank(curBank),
    .rspData(rspData), .rspDone(rspDone)
  );

endmodule

// File: tb/static_read_timer_tb.sv
`timescale 1ns/1ps
module static_read_timer_tb;

  localparam int HOLD = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlEnable = 1'b1, lowPower = 1'b0, pageModeEn = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [6:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        cfgErr;
  logic        reqValid = 1'b0;
  logic [1:0]  reqBank = '0;
  logic [15:0] reqAddr = '0;
  logic        reqReady, rspDone, memOeN;
  logic [15:0] rspData, memAddr;
  logic [15:0] memData = 16'hDEAD;
  logic [3:0]  memCsN;

  int nChecks = 0, nFail = 0, cycles = 0, curE = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  static_read_timer u_dut (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable), .lowPower(lowPower),
    .pageModeEn(pageModeEn), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .cfgErr(cfgErr),
    .reqValid(reqValid), .reqBank(reqBank), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspDone(rspDone), .rspData(rspData),
    .memAddr(memAddr), .memCsN(memCsN), .memOeN(memOeN), .memData(memData)
  );

  function automatic logic [15:0] fdat(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  // Memory model: correct word only in the cycle that must be sampled
  int          oeRun = 0;
  bit          pgRun = 0, prevOeLow = 0;
  logic [15:0] prevAddr = '0;
  always @(negedge clk) begin
    if (!memOeN) begin
      if (prevOeLow && memAddr != prevAddr) begin oeRun = 1; pgRun = 1; end
      else if (prevOeLow) oeRun++;
      else begin oeRun = 1; pgRun = 0; end
    end else begin
      oeRun = 0; pgRun = 0;
    end
    prevOeLow = !memOeN;
    prevAddr  = memAddr;
    memData = (!memOeN && oeRun == (pgRun ? 1 : curE + 1)) ? fdat(memAddr) : 16'hDEAD;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  task automatic cfgWrite(input int ofs, input logic [31:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 7'(ofs); cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input int ofs, output logic [31:0] val);
    cfgAddr = 7'(ofs);
    #1;
    val = cfgRdData;
  endtask

  task automatic runRead(input int bank, input logic [15:0] addr, input int d, input int e);
    int dly = 0, oeLow = 0, hold = 0, total = 0, dones = 0;
    bit seenOe = 0, badCs = 0, badAddr = 0, doneOk = 0;
    logic [15:0] got = '0;
    logic [3:0] other;
    curE = e;
    @(negedge clk);
    reqValid = 1'b1; reqBank = 2'(bank); reqAddr = addr;
    #1;
    chk(reqReady === 1'b1, "R2 ready in idle", longint'(reqReady), 1);
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 100; c++) begin
      #1;
      other = ~memCsN & ~(4'b0001 << bank);
      if (other != 4'b0000) badCs = 1;
      if (memCsN[bank] == 1'b0) begin
        total++;
        if (memAddr !== addr) badAddr = 1;
        if (!memOeN) begin oeLow++; seenOe = 1; end
        else if (!seenOe) dly++;
        else hold++;
      end else begin
        break;
      end
      if (rspDone) begin
        dones++; got = rspData;
        doneOk = seenOe && memOeN && hold == 1;
      end
      @(negedge clk);
    end
    chk(dly == d, "R3 oe assertion delay", dly, d);
    chk(oeLow == e + 1, "R3 oe low length", oeLow, e + 1);
    chk(hold == HOLD, "R5 hold length", hold, HOLD);
    if (d == 0 && e == 0)
      chk(total == 1 + HOLD, "R5 zero-wait cycle", total, 1 + HOLD);
    else
      chk(total == d + e + 1 + HOLD, "R5 cycle length", total, d + e + 1 + HOLD);
    chk(dones == 1 && doneOk, "R4 done pulse timing", dones, 1);
    chk(got == fdat(addr), "R4 sampled data", got, fdat(addr));
    chk(!badCs, "R6 only own chip select", badCs, 0);
    chk(!badAddr, "R2 address held", badAddr, 0);
  endtask

  task automatic runBurst(input bit pm, input int nExp,
                          input int e0, input int e1, input int e2, input int e3,
                          input bit pg1, input bit pg2, input bit pg3);
    logic [15:0] addrs [4];
    int expB [4];
    int bursts [8];
    bit pgExp [4];
    bit pgGot [4];
    int nb = 0, run = 0, idx = 0, doneIdx = 0, badData = 0;
    bit acc;
    addrs[0] = 16'h2230; addrs[1] = 16'h2231; addrs[2] = 16'h2233; addrs[3] = 16'h2240;
    expB[0] = e0; expB[1] = e1; expB[2] = e2; expB[3] = e3;
    pgExp[0] = 0; pgExp[1] = pg1; pgExp[2] = pg2; pgExp[3] = pg3;
    for (int i = 0; i < 4; i++) pgGot[i] = 0;
    pageModeEn = pm;
    curE = 3;
    @(negedge clk);
    reqValid = 1'b1; reqBank = 2'd1; reqAddr = addrs[0];
    for (int c = 0; c < 90; c++) begin
      #1;
      if (!memOeN) run++;
      else if (run > 0) begin
        if (nb < 8) bursts[nb] = run;
        nb++; run = 0;
      end
      if (rspDone) begin
        if (doneIdx < 4 && rspData != fdat(addrs[doneIdx])) badData++;
        doneIdx++;
      end
      acc = reqValid && reqReady;
      if (acc) pgGot[idx] = (memCsN != 4'hF);
      @(negedge clk);
      if (acc) begin
        idx++;
        if (idx < 4) reqAddr = addrs[idx];
        else reqValid = 1'b0;
      end
    end
    reqValid = 1'b0;
    chk(nb == nExp, pm ? "R10 burst count" : "R11 burst count", nb, nExp);
    for (int i = 0; i < nExp && i < 8; i++)
      chk(bursts[i] == expB[i], pm ? "R10 oe window length" : "R11 oe window length",
          bursts[i], expB[i]);
    chk(doneIdx == 4, "R10 done count", doneIdx, 4);
    chk(badData == 0, "R10 burst data", badData, 0);
    for (int i = 1; i < 4; i++)
      chk(pgGot[i] == pgExp[i], pgExp[i] ? "R10 taken inside window" : "R11 taken from idle",
          pgGot[i], pgExp[i]);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(memCsN == 4'hF, "R1 chip selects idle", memCsN, 15);
    chk(memOeN == 1'b1, "R1 output enable idle", memOeN, 1);
    chk(rspDone == 1'b0 && cfgErr == 1'b0, "R1 done and error clear", rspDone, 0);
    for (int b = 0; b < 4; b++) begin
      cfgRead(b * 32 + 12, v);
      chk(v == 31, "R1 read delay reset", v, 31);
      cfgRead(b * 32 + 8, v);
      chk(v == 0, "R1 assertion delay reset", v, 0);
    end

    // R3 R4 R5 R8: sweep both settings, rotating banks
    for (int d = 0; d < 5; d++) begin
      for (int e = 0; e < 5; e++) begin
        int bank = (d + e) % 4;
        cfgWrite(bank * 32 + 8, 32'(d));
        cfgWrite(bank * 32 + 12, 32'hFFFF_FF00 | 32'(e));
        cfgRead(bank * 32 + 12, v);
        chk(v == e, "R8 reserved bits read zero", v, e);
        runRead(bank, 16'h0100 + 16'(d * 16 + e), d, e);
      end
    end

    // R8 unmapped offset
    cfgWrite(0 * 32 + 8, 32'd3);
    cfgWrite(16, 32'hFF);
    cfgRead(16, v);
    chk(v == 0, "R8 unmapped offset reads zero", v, 0);
    cfgRead(8, v);
    chk(v == 3, "R8 unmapped write no effect", v, 3);

    // R6 per-bank independence
    cfgWrite(0 * 32 + 8, 32'd1);
    cfgWrite(0 * 32 + 12, 32'd2);
    cfgWrite(3 * 32 + 8, 32'd3);
    cfgWrite(3 * 32 + 12, 32'd0);
    runRead(0, 16'h0A10, 1, 2);
    runRead(3, 16'h0B20, 3, 0);
    runRead(0, 16'h0A14, 1, 2);

    // R7 disabled and low-power modes
    ctrlEnable = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqBank = 2'd0; reqAddr = 16'h0C00;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(reqReady == 1'b0 && memCsN == 4'hF, "R7 blocked when disabled", memCsN, 15);
      @(negedge clk);
    end
    ctrlEnable = 1'b1; lowPower = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(reqReady == 1'b0 && memCsN == 4'hF, "R7 blocked in low power", memCsN, 15);
      @(negedge clk);
    end
    reqValid = 1'b0; lowPower = 1'b0;
    runRead(0, 16'h0C04, 1, 2);

    // R9 write during a cycle
    cfgWrite(2 * 32 + 8, 32'd5);
    cfgWrite(2 * 32 + 12, 32'd5);
    curE = 5;
    @(negedge clk);
    reqValid = 1'b1; reqBank = 2'd2; reqAddr = 16'h0D00;
    @(negedge clk);
    reqValid = 1'b0;
    cfgWrite(2 * 32 + 12, 32'd1);
    repeat (20) @(negedge clk);
    cfgRead(2 * 32 + 12, v);
    chk(v == 5, "R9 busy write dropped", v, 5);
    chk(cfgErr == 1'b1, "R9 error flag set", cfgErr, 1);
    cfgWrite(2 * 32 + 12, 32'd5);
    #1;
    chk(cfgErr == 1'b0, "R9 idle write clears flag", cfgErr, 0);

    // R10 page bursts, R11 page change and page mode off
    cfgWrite(1 * 32 + 8, 32'd2);
    cfgWrite(1 * 32 + 12, 32'd3);
    runBurst(1'b1, 2, 6, 4, 0, 0, 1'b1, 1'b1, 1'b0);
    runBurst(1'b0, 4, 4, 4, 4, 4, 1'b0, 1'b0, 1'b0);
    pageModeEn = 1'b0;

    repeat (4) @(negedge clk);
    summary();
  end

endmodule